// File: doc/BRIEF.md
# Cartridge PRG/CHR bank-switching controller

This block is the bank-switching register file of an 8-bit console cartridge. The CPU programs it by writing into a sixteen-byte window at 0x7EF0–0x7EFF. The block holds three switchable 8 KB program banks. It also holds eight 1 KB pattern-table slots, a placement flag and a mirroring bit. From these it translates the CPU address (0x8000–0xFFFF) and the PPU pattern address (0x0000–0x1FFF) into ROM addresses. It also drives the nametable A10 line.

Pattern space is filled by two kinds of writes: two 2 KB bank registers and four 1 KB bank registers. A placement flag chooses which half of pattern space each kind lands in. The flag is applied at the moment a bank register is written. Toggling the flag later leaves the slots already loaded where they are. The last program window is hard-wired to the final bank of the ROM. The ROM size is a parameter counted in 8 KB banks, and bank numbers wrap at that count.

Top module: `bank_mapper`

## Requirements
- R1: After reset, program windows 0x8000/0xA000/0xC000/0xE000 map to banks 0, 1, PRG_BANKS-2 and PRG_BANKS-1. The 1 KB pattern slots 0..7 hold banks 0..7, the placement flag is clear and mirroring is vertical.
- R2: With the placement flag clear, a write to 0x7EF0 (or 0x7EF1) with data D loads slots 0,1 (or 2,3) with 1 KB banks {D[7:1],0} and {D[7:1],1}.
- R3: With the placement flag set, the same two writes load slots 4,5 (for 0x7EF0) and 6,7 (for 0x7EF1) in the same way.
- R4: With the placement flag clear, writes to 0x7EF2, 0x7EF3, 0x7EF4 and 0x7EF5 load slots 4, 5, 6 and 7 with the full data byte.
- R5: With the placement flag set, those four writes load slots 0, 1, 2 and 3 instead, and slots 4..7 are left unchanged.
- R6: A write to 0x7EF6 stores data bit 1 as the placement flag and data bit 0 as the mirroring mode (1 = vertical, 0 = horizontal).
- R7: Changing the placement flag moves no slot. Only later bank writes use the new placement.
- R8: Writes to 0x7EFA, 0x7EFB and 0x7EFC set the banks of the 0x8000, 0xA000 and 0xC000 windows to D[7:2] modulo PRG_BANKS.
- R9: The 0xE000 window always maps to bank PRG_BANKS-1.
- R10: Writes to 0x7EF7–0x7EF9, 0x7EFD–0x7EFF or outside the window, and all cycles without the write strobe, leave every bank, the flag and the mirroring unchanged.
- R11: nt_a10_o equals ppu_addr_i[10] under vertical mirroring and ppu_addr_i[11] under horizontal mirroring.
- R12: prg_addr_o is {bank, cpu_addr_i[12:0]} with the window chosen by cpu_addr_i[14:13]. chr_addr_o is {slot bank, ppu_addr_i[9:0]} with the slot chosen by ppu_addr_i[12:10].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU-side clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_addr_i | input | 16 | CPU address |
| cpu_data_i | input | 8 | CPU write data |
| cpu_we_i | input | 1 | CPU write strobe, sampled on the rising clock edge |
| ppu_addr_i | input | 14 | PPU address |
| prg_addr_o | output | $clog2(PRG_BANKS)+13 | Program ROM byte address |
| chr_addr_o | output | 18 | Pattern ROM byte address |
| nt_a10_o | output | 1 | Nametable A10 select |

## Verification
The bank writes are tried once with the placement flag clear and once with it set. Each time both the 2 KB and the 1 KB registers are written, so a design that ignores the flag or applies it to only one kind of register puts data in the wrong half. Between the two phases the flag is toggled with no bank write, and the old slots are read back, which separates placement at write time from placement at read time. Program bank values above the ROM size check the wrap, and writes to the unlisted offsets and strobe-less cycles check that state is held. Both mirroring modes are probed with PPU addresses that differ only in bit 10 or only in bit 11.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned CHR_BW  = DATA_W;      // 1 KB bank number width
  localparam int unsigned SLOTS   = 8;
  localparam int unsigned SLOT_AW = $clog2(SLOTS);
  localparam int unsigned PRG_RAW = DATA_W - 2;  // raw 8 KB bank field
  localparam logic [11:0] WIN_TAG = 12'h7EF;

  typedef enum logic [3:0] {
    OFS_CHR2K_A = 4'h0,
    OFS_CHR2K_B = 4'h1,
    OFS_CHR1K_0 = 4'h2,
    OFS_CHR1K_1 = 4'h3,
    OFS_CHR1K_2 = 4'h4,
    OFS_CHR1K_3 = 4'h5,
    OFS_CTRL    = 4'h6,
    OFS_PRG_0   = 4'hA,
    OFS_PRG_1   = 4'hB,
    OFS_PRG_2   = 4'hC
  } reg_ofs_e;
endpackage

// File: rtl/bank_reg_decode.sv
module bank_reg_decode
  import bankmap_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] cpu_addr_i,
  input  logic        cpu_we_i,
  output logic        chr2k_we_o,
  output logic        chr2k_idx_o,
  output logic        chr1k_we_o,
  output logic [1:0]  chr1k_idx_o,
  output logic        ctrl_we_o,
  output logic        prg_we_o,
  output logic [1:0]  prg_idx_o
);
  logic     win_hit;
  reg_ofs_e ofs;

  assign win_hit = cpu_we_i && (cpu_addr_i[15:4] == WIN_TAG);
  assign ofs     = reg_ofs_e'(cpu_addr_i[3:0]);

  always_comb begin
    chr2k_we_o  = 1'b0;
    chr2k_idx_o = 1'b0;
    chr1k_we_o  = 1'b0;
    chr1k_idx_o = 2'd0;
    ctrl_we_o   = 1'b0;
    prg_we_o    = 1'b0;
    prg_idx_o   = 2'd0;
    if (win_hit) begin
      case (ofs)
        OFS_CHR2K_A: begin chr2k_we_o = 1'b1; chr2k_idx_o = 1'b0; end
        OFS_CHR2K_B: begin chr2k_we_o = 1'b1; chr2k_idx_o = 1'b1; end
        OFS_CHR1K_0: begin chr1k_we_o = 1'b1; chr1k_idx_o = 2'd0; end
        OFS_CHR1K_1: begin chr1k_we_o = 1'b1; chr1k_idx_o = 2'd1; end
        OFS_CHR1K_2: begin chr1k_we_o = 1'b1; chr1k_idx_o = 2'd2; end
        OFS_CHR1K_3: begin chr1k_we_o = 1'b1; chr1k_idx_o = 2'd3; end
        OFS_CTRL:    ctrl_we_o = 1'b1;
        OFS_PRG_0:   begin prg_we_o = 1'b1; prg_idx_o = 2'd0; end
        OFS_PRG_1:   begin prg_we_o = 1'b1; prg_idx_o = 2'd1; end
        OFS_PRG_2:   begin prg_we_o = 1'b1; prg_idx_o = 2'd2; end
        default: ;
      endcase
    end
  end

  // R10: no strobe without a write into the window
  a_r10_no_stray_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_we_i || cpu_addr_i[15:4] != WIN_TAG)
      |-> !(chr2k_we_o || chr1k_we_o || ctrl_we_o || prg_we_o));

  // R10: unlisted offsets decode to nothing
  a_r10_unlisted_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i[3:0] inside {4'h7, 4'h8, 4'h9, 4'hD, 4'hE, 4'hF})
      |-> !(chr2k_we_o || chr1k_we_o || ctrl_we_o || prg_we_o));

  a_r10_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({chr2k_we_o, chr1k_we_o, ctrl_we_o, prg_we_o}));
endmodule

// File: rtl/bank_chr_slots.sv
module bank_chr_slots
  import bankmap_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                chr2k_we_i,
  input  logic                chr2k_idx_i,
  input  logic                chr1k_we_i,
  input  logic [1:0]          chr1k_idx_i,
  input  logic                ctrl_we_i,
  input  logic [DATA_W-1:0]   data_i,
  input  logic [SLOT_AW-1:0]  slot_sel_i,
  output logic [CHR_BW-1:0]   bank_o
);
  logic                          swap_q;
  logic [SLOTS-1:0][CHR_BW-1:0]  slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        swap_q <= 1'b0;
    else if (ctrl_we_i) swap_q <= data_i[1];
  end

  // placement is taken from swap_q at the write, never at the read
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam logic [SLOT_AW-1:0] SID = SLOT_AW'(s);
    logic hit2k, hit1k;
    assign hit2k = chr2k_we_i && (SID[2] == swap_q)  && (SID[1] == chr2k_idx_i);
    assign hit1k = chr1k_we_i && (SID[2] != swap_q)  && (SID[1:0] == chr1k_idx_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    slot_q[s] <= CHR_BW'(s);
      else if (hit2k) slot_q[s] <= {data_i[DATA_W-1:1], SID[0]};
      else if (hit1k) slot_q[s] <= data_i;
    end
  end

  assign bank_o = slot_q[slot_sel_i];

  // R7: a flag write alone moves no slot
  a_r7_flag_moves_nothing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> $stable(slot_q));

  // R2: lower-half placement of the first 2 KB register
  a_r2_lower_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chr2k_we_i && !chr2k_idx_i && !swap_q)
      |=> (slot_q[0] == {$past(data_i[DATA_W-1:1]), 1'b0})
       && (slot_q[1] == {$past(data_i[DATA_W-1:1]), 1'b1}));

  // R5: 1 KB writes under swap leave the upper half alone
  a_r5_upper_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chr1k_we_i && swap_q) |=> $stable(slot_q[SLOTS-1:SLOTS/2]));

  // R3: 2 KB writes under swap leave the lower half alone
  a_r3_lower_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chr2k_we_i && swap_q) |=> $stable(slot_q[SLOTS/2-1:0]));
endmodule

// File: rtl/bank_prg_map.sv
module bank_prg_map
  import bankmap_pkg::*;
#(
  parameter int unsigned PRG_BANKS = 16,
  localparam int unsigned PRG_BW   = (PRG_BANKS > 2) ? $clog2(PRG_BANKS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                prg_we_i,
  input  logic [1:0]          prg_idx_i,
  input  logic [PRG_RAW-1:0]  bank_raw_i,
  input  logic [14:0]         cpu_addr_i,
  output logic [PRG_BW+12:0]  prg_addr_o
);
  localparam logic [PRG_BW-1:0] LAST = PRG_BW'(PRG_BANKS - 1);
  localparam logic [PRG_BW-1:0] PENU = PRG_BW'(PRG_BANKS - 2);

  logic [2:0][PRG_BW-1:0] bank_q;
  logic [PRG_BW-1:0]      bank_wrap;
  logic [PRG_BW-1:0]      bank_sel;

  assign bank_wrap = PRG_BW'(32'(bank_raw_i) % PRG_BANKS);

  for (genvar w = 0; w < 3; w++) begin : g_win
    localparam logic [PRG_BW-1:0] RST = (w == 2) ? PENU : PRG_BW'(w);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   bank_q[w] <= RST;
      else if (prg_we_i && prg_idx_i == 2'(w))       bank_q[w] <= bank_wrap;
    end
  end

  always_comb begin
    if (cpu_addr_i[14:13] == 2'b11) bank_sel = LAST;
    else                            bank_sel = bank_q[cpu_addr_i[14:13]];
  end

  assign prg_addr_o = {bank_sel, cpu_addr_i[12:0]};

  // R8: stored banks always inside the ROM
  a_r8_bank_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(bank_q[0]) < PRG_BANKS) && (32'(bank_q[1]) < PRG_BANKS)
      && (32'(bank_q[2]) < PRG_BANKS));

  // R8: an idle cycle keeps every bank
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prg_we_i |=> $stable(bank_q));
endmodule

// File: rtl/bank_mirror.sv
module bank_mirror (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_we_i,
  input  logic mode_i,
  input  logic ppu_a10_i,
  input  logic ppu_a11_i,
  output logic nt_a10_o
);
  logic vert_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        vert_q <= 1'b1;
    else if (ctrl_we_i) vert_q <= mode_i;
  end

  assign nt_a10_o = vert_q ? ppu_a10_i : ppu_a11_i;

  // R6: mode bit captured on the control write
  a_r6_mode_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> vert_q == $past(mode_i));

  a_r10_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we_i |=> $stable(vert_q));
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bankmap_pkg::*;
#(
  parameter int unsigned PRG_BANKS = 16,
  localparam int unsigned PRG_BW   = (PRG_BANKS > 2) ? $clog2(PRG_BANKS) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [15:0]             cpu_addr_i,
  input  logic [DATA_W-1:0]       cpu_data_i,
  input  logic                    cpu_we_i,
  input  logic [13:0]             ppu_addr_i,
  output logic [PRG_BW+12:0]      prg_addr_o,
  output logic [CHR_BW+9:0]       chr_addr_o,
  output logic                    nt_a10_o
);
  logic              chr2k_we, chr2k_idx, chr1k_we, ctrl_we, prg_we;
  logic [1:0]        chr1k_idx, prg_idx;
  logic [CHR_BW-1:0] chr_bank;
  logic              unused_ppu_a13;

  assign unused_ppu_a13 = ppu_addr_i[13];

  bank_reg_decode u_decode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_addr_i  (cpu_addr_i),
    .cpu_we_i    (cpu_we_i),
    .chr2k_we_o  (chr2k_we),
    .chr2k_idx_o (chr2k_idx),
    .chr1k_we_o  (chr1k_we),
    .chr1k_idx_o (chr1k_idx),
    .ctrl_we_o   (ctrl_we),
    .prg_we_o    (prg_we),
    .prg_idx_o   (prg_idx)
  );

  bank_chr_slots u_chr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .chr2k_we_i  (chr2k_we),
    .chr2k_idx_i (chr2k_idx),
    .chr1k_we_i  (chr1k_we),
    .chr1k_idx_i (chr1k_idx),
    .ctrl_we_i   (ctrl_we),
    .data_i      (cpu_data_i),
    .slot_sel_i  (ppu_addr_i[12:10]),
    .bank_o      (chr_bank)
  );

  bank_prg_map #(.PRG_BANKS(PRG_BANKS)) u_prg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .prg_we_i   (prg_we),
    .prg_idx_i  (prg_idx),
    .bank_raw_i (cpu_data_i[DATA_W-1:2]),
    .cpu_addr_i (cpu_addr_i[14:0]),
    .prg_addr_o (prg_addr_o)
  );

  bank_mirror u_mirror (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_we_i (ctrl_we),
    .mode_i    (cpu_data_i[0]),
    .ppu_a10_i (ppu_addr_i[10]),
    .ppu_a11_i (ppu_addr_i[11]),
    .nt_a10_o  (nt_a10_o)
  );

  assign chr_addr_o = {chr_bank, ppu_addr_i[9:0]};

  // R12: offset inside a 1 KB slot passes straight through
  a_r12_chr_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chr_addr_o[9:0] == ppu_addr_i[9:0]);
endmodule

// File: tb/bank_mapper_bench.sv
module bank_mapper_bench;
  localparam int PRG_BANKS = 16;
  localparam int PRG_BW    = 4;
  localparam int NV        = 19;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cpu_addr_i = '0;
  logic [7:0]  cpu_data_i = '0;
  logic        cpu_we_i = 1'b0;
  logic [13:0] ppu_addr_i = '0;
  logic [PRG_BW+12:0] prg_addr_o;
  logic [17:0] chr_addr_o;
  logic        nt_a10_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bank_mapper #(.PRG_BANKS(PRG_BANKS)) u_bank_mapper (
    .clk_i(clk), .rst_ni(rst_ni), .cpu_addr_i(cpu_addr_i), .cpu_data_i(cpu_data_i),
    .cpu_we_i(cpu_we_i), .ppu_addr_i(ppu_addr_i), .prg_addr_o(prg_addr_o),
    .chr_addr_o(chr_addr_o), .nt_a10_o(nt_a10_o)
  );

  // {write addr, write data, probe kind (0 chr / 1 prg), probe addr, expected bank, req}
  localparam logic [56:0] VEC [NV] = '{
    {16'h7EF0, 8'h0B, 1'b0, 16'h0000, 8'd10,  8'd2},  // R2 bank 5 -> slot0 = 10
    {16'h0000, 8'hFF, 1'b0, 16'h0400, 8'd11,  8'd2},  // R2 slot1 = 11
    {16'h7EF1, 8'h20, 1'b0, 16'h0800, 8'd32,  8'd2},  // R2 slot2
    {16'h0000, 8'h00, 1'b0, 16'h0C00, 8'd33,  8'd2},  // R2 slot3
    {16'h7EF2, 8'h81, 1'b0, 16'h1000, 8'h81,  8'd4},  // R4 slot4
    {16'h7EF5, 8'hC3, 1'b0, 16'h1C00, 8'hC3,  8'd4},  // R4 slot7
    {16'h7EF6, 8'h02, 1'b0, 16'h0000, 8'd10,  8'd7},  // R6 flag set, R7 slot0 kept
    {16'h7EF0, 8'h0E, 1'b0, 16'h1000, 8'd14,  8'd3},  // R3 slot4
    {16'h0000, 8'h00, 1'b0, 16'h1400, 8'd15,  8'd3},  // R3 slot5
    {16'h7EF1, 8'hFF, 1'b0, 16'h1800, 8'hFE,  8'd3},  // R3 slot6
    {16'h7EF3, 8'h44, 1'b0, 16'h0400, 8'h44,  8'd5},  // R5 slot1
    {16'h7EF4, 8'h55, 1'b0, 16'h0800, 8'h55,  8'd5},  // R5 slot2
    {16'h7EF7, 8'h99, 1'b0, 16'h0800, 8'h55,  8'd10}, // R10 unlisted offset
    {16'h7EFA, 8'h50, 1'b1, 16'h8000, 8'd4,   8'd8},  // R8 20 mod 16
    {16'h7EFB, 8'h0C, 1'b1, 16'hA000, 8'd3,   8'd8},  // R8
    {16'h7EFC, 8'hFC, 1'b1, 16'hC000, 8'd15,  8'd8},  // R8 63 mod 16
    {16'h7EFD, 8'h00, 1'b1, 16'hE000, 8'd15,  8'd9},  // R9 fixed last, R10
    {16'h7EF6, 8'h01, 1'b0, 16'h0400, 8'h44,  8'd7},  // R7 flag clear, slot1 kept
    {16'h7EF2, 8'h12, 1'b0, 16'h1000, 8'h12,  8'd4}   // R4 back to upper half
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic we);
    @(negedge clk);
    cpu_addr_i = a; cpu_data_i = d; cpu_we_i = we;
    @(negedge clk);
    cpu_we_i = 1'b0;
  endtask

  task automatic chr_bank(input logic [13:0] p, output logic [7:0] b);
    ppu_addr_i = p; #1; b = chr_addr_o[17:10];
  endtask

  task automatic prg_bank(input logic [15:0] a, output logic [PRG_BW-1:0] b);
    cpu_addr_i = a; #1; b = prg_addr_o[PRG_BW+12:13];
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] cb;
    logic [PRG_BW-1:0] pb;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int k = 0; k < 8; k++) begin
      chr_bank(14'(k * 'h400), cb);
      check("R1 chr slot", 32'(cb), 32'(k));
    end
    prg_bank(16'h8000, pb); check("R1 prg 8000", 32'(pb), 0);
    prg_bank(16'hA000, pb); check("R1 prg A000", 32'(pb), 1);
    prg_bank(16'hC000, pb); check("R1 prg C000", 32'(pb), PRG_BANKS - 2);
    prg_bank(16'hE000, pb); check("R1 prg E000", 32'(pb), PRG_BANKS - 1);
    ppu_addr_i = 14'h0400; #1; check("R1 R11 vertical a10", 32'(nt_a10_o), 1);
    ppu_addr_i = 14'h0800; #1; check("R1 R11 vertical a11", 32'(nt_a10_o), 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [56:0] v;
      string tag;
      v = VEC[i];
      wr(v[56:41], v[40:33], 1'b1);
      tag = $sformatf("R%0d vec%0d", v[7:0], i);
      if (v[32]) begin
        prg_bank(v[31:16], pb); check(tag, 32'(pb), 32'(v[15:8]));
      end else begin
        chr_bank(v[29:16], cb); check(tag, 32'(cb), 32'(v[15:8]));
      end
    end

    // R10 strobe low into a live register
    wr(16'h7EF2, 8'hAA, 1'b0);
    chr_bank(14'h1000, cb); check("R10 no strobe", 32'(cb), 32'h12);

    // R11 R6 horizontal mirroring
    wr(16'h7EF6, 8'h00, 1'b1);
    ppu_addr_i = 14'h0800; #1; check("R11 horizontal a11", 32'(nt_a10_o), 1);
    ppu_addr_i = 14'h0400; #1; check("R11 horizontal a10", 32'(nt_a10_o), 0);
    wr(16'h7EFF, 8'h01, 1'b1);
    ppu_addr_i = 14'h0400; #1; check("R10 mirror held", 32'(nt_a10_o), 0);

    // R12 offsets
    cpu_addr_i = 16'h9ABC; #1; check("R12 prg offset", 32'(prg_addr_o[12:0]), 32'h1ABC);
    ppu_addr_i = 14'h17FF; #1; check("R12 chr offset", 32'(chr_addr_o[9:0]), 32'h3FF);
    check("R12 chr slot5", 32'(chr_addr_o[17:10]), 15);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule